// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block derives a slow clock from a fast reference clock. With one divide ratio the output period is a fixed whole number of reference cycles. When the two-ratio mode is on, the block runs a burst of periods at a first ratio and then a burst at a second ratio, and repeats the pair. Over one full pattern the average frequency sits between the two integer quotients. A typical use is a low-power timekeeping clock near 32.768 kHz made from a reference frequency that does not divide to it evenly.

The configuration arrives as plain register-style inputs: a mode bit, two divide fields and two repeat-count fields. The block keeps a private shadow copy and refreshes it only at safe points, so a period is never cut short and never mixes two settings. Next to the clock it drives a one-cycle strobe on the first reference cycle of every output period, and a flag that shows which ratio is active.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While reset is low, `clk_out`, `period_start` and `path_b` are all 0. The first output period after reset uses the first ratio.
- R2: When `cfg_dual` = 0, every output period lasts the first divide value and `path_b` stays 0. The second divide field and both repeat fields have no effect.
- R3: When `cfg_dual` = 1, the block emits A-repeat periods of A-divide cycles, then B-repeat periods of B-divide cycles, and repeats this sequence. One pattern therefore spans A-div×A-rep + B-div×B-rep reference cycles for A-rep + B-rep periods.
- R4: Each divide and repeat field holds its value minus one. A field of 0 gives a one-cycle period or a single repeat.
- R5: `clk_out` is high for the first floor(N/2) reference cycles of an N-cycle period and low for the rest. When N = 1 it is high for the whole cycle, the same as the strobe.
- R6: `period_start` is high for exactly one reference cycle, the first cycle of each output period.
- R7: `path_b` is 1 while the second ratio drives the output and 0 while the first does. It changes only in a cycle where `period_start` is high.
- R8: In two-ratio mode, changed configuration inputs take effect only once the current pattern has finished its second burst.
- R9: In one-ratio mode, changed configuration inputs, including the mode bit, take effect at the next output period boundary.
- R10: Neither repeat counter ever exceeds its programmed field value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | 1 selects two-ratio mode, 0 selects one-ratio mode |
| cfg_div_a | input | DIV_W | First divide value minus one |
| cfg_rpt_a | input | RPT_W | Periods at the first ratio per pattern, minus one |
| cfg_div_b | input | DIV_W | Second divide value minus one |
| cfg_rpt_b | input | RPT_W | Periods at the second ratio per pattern, minus one |
| clk_out | output | 1 | Divided clock |
| period_start | output | 1 | High on the first reference cycle of every output period |
| path_b | output | 1 | High while the second ratio is active |

## Verification
The checker watches the local invariants on every cycle: quiet outputs during reset, a high output on each strobe cycle, single-cycle strobes whenever the period is longer than one cycle, the active flag moving only on a strobe and staying low in one-ratio mode, and both repeat counters and the phase counter staying inside their programmed bounds. Properties like these cannot show that the sequence is right. Period lengths, high-phase widths, the order and size of the two bursts, the average over a pattern, and the exact period in which new settings take hold are measured by the bench scenarios, which count reference cycles between strobes.

// File: rtl/dualdiv_pkg.sv
`timescale 1ns/1ps
package dualdiv_pkg;

   // Which divide path currently owns the output.
   typedef enum logic {
      PATH_A = 1'b0,
      PATH_B = 1'b1
   } path_e;

   localparam int NUM_PATHS = 2;

endpackage

// File: rtl/dualdiv_shadow.sv
`timescale 1ns/1ps
// Working copy of the configuration; refreshed only when load is high.
module dualdiv_shadow #(
   parameter int DIV_W = 12,
   parameter int RPT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             in_dual,
   input  logic [DIV_W-1:0] in_div_a,
   input  logic [RPT_W-1:0] in_rpt_a,
   input  logic [DIV_W-1:0] in_div_b,
   input  logic [RPT_W-1:0] in_rpt_b,
   output logic             dual_q,
   output logic [DIV_W-1:0] div_a_q,
   output logic [RPT_W-1:0] rpt_a_q,
   output logic [DIV_W-1:0] div_b_q,
   output logic [RPT_W-1:0] rpt_b_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dual_q  <= 1'b0;
         div_a_q <= '0;
         rpt_a_q <= '0;
         div_b_q <= '0;
         rpt_b_q <= '0;
      end else if (load) begin
         dual_q  <= in_dual;
         div_a_q <= in_div_a;
         rpt_a_q <= in_rpt_a;
         div_b_q <= in_div_b;
         rpt_b_q <= in_rpt_b;
      end
   end

endmodule

// File: rtl/dualdiv_phase.sv
`timescale 1ns/1ps
// Counts reference cycles inside one output period and shapes the waveform.
module dualdiv_phase #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_field,
   output logic             at_end,
   output logic             first,
   output logic             wave_high,
   output logic [DIV_W-1:0] cnt_o
);

   localparam logic [DIV_W:0] ONE_W = {{DIV_W{1'b0}}, 1'b1};

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W:0]   half_w;
   logic             single_cycle;

   always_comb begin
      // floor(N/2) where N = field + 1
      half_w       = ({1'b0, div_field} + ONE_W) >> 1;
      single_cycle = (div_field == '0);
      at_end       = run && (cnt_q == div_field);
      first        = run && (cnt_q == '0);
      wave_high    = run && (single_cycle ? first : ({1'b0, cnt_q} < half_w));
      cnt_o        = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dualdiv_repeat.sv
`timescale 1ns/1ps
// Counts completed periods of one path; wrap marks the last one of its burst.
module dualdiv_repeat #(
   parameter int RPT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [RPT_W-1:0] limit,
   output logic             wrap,
   output logic [RPT_W-1:0] count
);

   always_comb wrap = (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (step) begin
         count <= wrap ? '0 : count + 1'b1;
      end
   end

endmodule

// File: rtl/dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv #(
   parameter int DIV_W = 12,
   parameter int RPT_W = 12
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             cfg_dual,
   input  logic [DIV_W-1:0] cfg_div_a,
   input  logic [RPT_W-1:0] cfg_rpt_a,
   input  logic [DIV_W-1:0] cfg_div_b,
   input  logic [RPT_W-1:0] cfg_rpt_b,
   output logic             clk_out,
   output logic             period_start,
   output logic             path_b
);
   import dualdiv_pkg::*;

   localparam int NP = NUM_PATHS;

   // elaboration-time parameter checks
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div_w
      $error("dual_ratio_clkdiv: DIV_W must lie in 1..32");
   end
   if (RPT_W < 1 || RPT_W > 32) begin : g_bad_rpt_w
      $error("dual_ratio_clkdiv: RPT_W must lie in 1..32");
   end

   logic             live_q;
   path_e            path_q;
   logic             shadow_load;
   logic             dual_q;
   logic [DIV_W-1:0] div_a_q;
   logic [DIV_W-1:0] div_b_q;
   logic [RPT_W-1:0] rpt_a_q;
   logic [RPT_W-1:0] rpt_b_q;
   logic [DIV_W-1:0] div_act;
   logic             at_end;
   logic             first;
   logic             wave_high;
   logic [DIV_W-1:0] phase_cnt;
   logic             period_end;
   logic [NP-1:0]    rpt_step;
   logic [NP-1:0]    rpt_wrap;
   logic [RPT_W-1:0] rpt_lim [NP];
   logic [RPT_W-1:0] rpt_cnt [NP];
   logic             pattern_done;

   dualdiv_shadow #(.DIV_W(DIV_W), .RPT_W(RPT_W)) u_shadow (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .load     (shadow_load),
      .in_dual  (cfg_dual),
      .in_div_a (cfg_div_a),
      .in_rpt_a (cfg_rpt_a),
      .in_div_b (cfg_div_b),
      .in_rpt_b (cfg_rpt_b),
      .dual_q   (dual_q),
      .div_a_q  (div_a_q),
      .rpt_a_q  (rpt_a_q),
      .div_b_q  (div_b_q),
      .rpt_b_q  (rpt_b_q)
   );

   always_comb div_act = (path_q == PATH_B) ? div_b_q : div_a_q;

   dualdiv_phase #(.DIV_W(DIV_W)) u_phase (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .run       (live_q),
      .div_field (div_act),
      .at_end    (at_end),
      .first     (first),
      .wave_high (wave_high),
      .cnt_o     (phase_cnt)
   );

   always_comb begin
      period_end  = live_q && at_end;
      rpt_lim[0]  = rpt_a_q;
      rpt_lim[1]  = rpt_b_q;
      rpt_step[0] = period_end && dual_q && (path_q == PATH_A);
      rpt_step[1] = period_end && dual_q && (path_q == PATH_B);
   end

   for (genvar g = 0; g < NP; g++) begin : g_rpt
      dualdiv_repeat #(.RPT_W(RPT_W)) u_rpt (
         .clk   (clk_ref),
         .rst_n (rst_n),
         .step  (rpt_step[g]),
         .limit (rpt_lim[g]),
         .wrap  (rpt_wrap[g]),
         .count (rpt_cnt[g])
      );
   end

   always_comb begin
      pattern_done = (path_q == PATH_B) && rpt_wrap[1];
      shadow_load  = !live_q || (period_end && (!dual_q || pattern_done));
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         path_q <= PATH_A;
      end else begin
         live_q <= 1'b1;
         if (period_end) begin
            if (!dual_q) begin
               path_q <= PATH_A;
            end else if (path_q == PATH_A && rpt_wrap[0]) begin
               path_q <= PATH_B;
            end else if (pattern_done) begin
               path_q <= PATH_A;
            end
         end
      end
   end

   always_comb begin
      clk_out      = wave_high;
      period_start = first;
      path_b       = (path_q == PATH_B);
   end

endmodule

// File: rtl/dualdiv_sva.sv
`timescale 1ns/1ps
module dualdiv_sva #(
   parameter int DIV_W = 12,
   parameter int RPT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_out,
   input logic             period_start,
   input logic             path_b,
   input logic             dual_q,
   input logic [DIV_W-1:0] div_act,
   input logic [DIV_W-1:0] phase_cnt,
   input logic [RPT_W-1:0] rpt_a,
   input logic [RPT_W-1:0] rpt_b,
   input logic [RPT_W-1:0] lim_a,
   input logic [RPT_W-1:0] lim_b
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!clk_out && !period_start && !path_b));

   assert_single_path_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_q |-> !path_b);

   assert_start_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> clk_out);

   assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && div_act != '0) |=> !period_start);

   assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cnt <= div_act);

   assert_path_moves_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(path_b) |-> period_start);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_a <= lim_a) && (rpt_b <= lim_b));

endmodule

bind dual_ratio_clkdiv dualdiv_sva #(.DIV_W(DIV_W), .RPT_W(RPT_W)) u_sva (
   .clk          (clk_ref),
   .rst_n        (rst_n),
   .clk_out      (clk_out),
   .period_start (period_start),
   .path_b       (path_b),
   .dual_q       (dual_q),
   .div_act      (div_act),
   .phase_cnt    (phase_cnt),
   .rpt_a        (rpt_cnt[0]),
   .rpt_b        (rpt_cnt[1]),
   .lim_a        (rpt_a_q),
   .lim_b        (rpt_b_q)
);

// File: tb/dual_ratio_clkdiv_test.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv_test;

   localparam int DW = 12;
   localparam int RW = 12;

   logic          clk_ref = 1'b0;
   logic          rst_n   = 1'b0;
   logic          cfg_dual = 1'b0;
   logic [DW-1:0] cfg_div_a = '0;
   logic [RW-1:0] cfg_rpt_a = '0;
   logic [DW-1:0] cfg_div_b = '0;
   logic [RW-1:0] cfg_rpt_b = '0;
   logic          clk_out;
   logic          period_start;
   logic          path_b;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int lens  [64];
   int highs [64];
   int sels  [64];

   always #5 clk_ref = ~clk_ref;

   dual_ratio_clkdiv #(.DIV_W(DW), .RPT_W(RW)) uut (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .cfg_dual     (cfg_dual),
      .cfg_div_a    (cfg_div_a),
      .cfg_rpt_a    (cfg_rpt_a),
      .cfg_div_b    (cfg_div_b),
      .cfg_rpt_b    (cfg_rpt_b),
      .clk_out      (clk_out),
      .period_start (period_start),
      .path_b       (path_b)
   );

   always @(posedge clk_ref) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input bit d, input int na, input int ma, input int nb, input int mb);
      cfg_dual  = d;
      cfg_div_a = DW'(na);
      cfg_rpt_a = RW'(ma);
      cfg_div_b = DW'(nb);
      cfg_rpt_b = RW'(mb);
   endtask

   // reset, release, then stop at the negedge of the first strobe
   task automatic restart;
      @(negedge clk_ref);
      rst_n = 1'b0;
      repeat (3) @(negedge clk_ref);
      rst_n = 1'b1;
      do @(negedge clk_ref); while (!period_start);
   endtask

   // called at a strobe negedge; measures k periods
   task automatic capture(input int k);
      for (int i = 0; i < k; i++) begin
         int len = 0;
         int hi  = 0;
         sels[i] = int'(path_b);
         do begin
            len = len + 1;
            hi  = hi + int'(clk_out);
            @(negedge clk_ref);
         end while (!period_start);
         lens[i]  = len;
         highs[i] = hi;
      end
   endtask

   // compare periods lo..hi-1 against a configuration whose pattern begins at base
   task automatic check_range(input string req, input int lo, input int hi, input int base,
                              input bit d, input int na, input int ma, input int nb, input int mb);
      for (int i = lo; i < hi; i++) begin
         int p   = i - base;
         int sel = 0;
         int n;
         int eh;
         if (d) begin
            sel = ((p % (ma + mb + 2)) >= (ma + 1)) ? 1 : 0;
         end
         n  = (sel == 1) ? nb + 1 : na + 1;
         eh = (n == 1) ? 1 : n / 2;
         check_eq(req, $sformatf("period %0d length", i), lens[i], n);
         check_eq("R5", $sformatf("period %0d high cycles", i), highs[i], eh);
         check_eq("R7", $sformatf("period %0d path", i), sels[i], sel);
      end
   endtask

   task automatic t_reset_state;
      set_cfg(1'b0, 4, 0, 0, 0);
      @(negedge clk_ref);
      rst_n = 1'b0;
      repeat (2) @(negedge clk_ref);
      check_eq("R1", "clk_out in reset", int'(clk_out), 0);
      check_eq("R1", "period_start in reset", int'(period_start), 0);
      check_eq("R1", "path_b in reset", int'(path_b), 0);
      rst_n = 1'b1;
      do @(negedge clk_ref); while (!period_start);
      check_eq("R1", "first period path", int'(path_b), 0);
      capture(1);
      check_eq("R1", "first period length", lens[0], 5);
   endtask

   task automatic t_single;
      // second divide and both repeat fields set to values that must not matter
      set_cfg(1'b0, 4, 3, 9, 2);
      restart();
      capture(6);
      check_range("R2", 0, 6, 0, 1'b0, 4, 3, 9, 2);
      set_cfg(1'b0, 7, 1, 0, 1);
      restart();
      capture(4);
      check_range("R2", 0, 4, 0, 1'b0, 7, 1, 0, 1);
   endtask

   task automatic t_single_min;
      set_cfg(1'b0, 0, 0, 5, 0);
      restart();
      capture(5);
      check_range("R4", 0, 5, 0, 1'b0, 0, 0, 5, 0);
   endtask

   task automatic t_dual;
      int sum = 0;
      set_cfg(1'b1, 2, 1, 3, 2);
      restart();
      capture(15);
      check_range("R3", 0, 15, 0, 1'b1, 2, 1, 3, 2);
      for (int i = 0; i < 5; i++) sum = sum + lens[i];
      check_eq("R3", "cycles per pattern", sum, 18);
   endtask

   task automatic t_dual_min;
      set_cfg(1'b1, 0, 0, 0, 0);
      restart();
      capture(8);
      check_range("R4", 0, 8, 0, 1'b1, 0, 0, 0, 0);
   endtask

   task automatic t_dual_reload;
      set_cfg(1'b1, 2, 1, 3, 2);
      restart();
      set_cfg(1'b1, 1, 0, 4, 0);
      capture(9);
      check_range("R8", 0, 5, 0, 1'b1, 2, 1, 3, 2);
      check_range("R8", 5, 9, 5, 1'b1, 1, 0, 4, 0);
   endtask

   task automatic t_single_reload;
      set_cfg(1'b0, 5, 0, 0, 0);
      restart();
      set_cfg(1'b0, 2, 0, 0, 0);
      capture(4);
      check_range("R9", 0, 1, 0, 1'b0, 5, 0, 0, 0);
      check_range("R9", 1, 4, 1, 1'b0, 2, 0, 0, 0);
   endtask

   task automatic t_mode_switch;
      set_cfg(1'b0, 3, 0, 0, 0);
      restart();
      set_cfg(1'b1, 2, 1, 3, 2);
      capture(6);
      check_range("R9", 0, 1, 0, 1'b0, 3, 0, 0, 0);
      check_range("R9", 1, 6, 1, 1'b1, 2, 1, 3, 2);
   endtask

   initial begin
      t_reset_state();
      t_single();
      t_single_min();
      t_dual();
      t_dual_min();
      t_dual_reload();
      t_single_reload();
      t_mode_switch();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule